// File: doc/BRIEF.md
# Sleep Mode and Wake-up Controller

This block sequences a processor core into and out of four low-power modes. A sleep-instruction strobe is accepted only while the sleep-enable bit is set; the 2-bit mode select is captured at that moment. While asleep, the block gates the CPU, flash, I/O and ADC clock domains according to the captured mode. It stops the oscillator in the deepest mode, and it can fire a one-cycle pulse that starts an ADC conversion when the mode keeps the converter clocked.

Wake-up requests arrive as a vector of enabled interrupt sources, one bit per source type. Each mode accepts its own subset of these sources. A wake from the oscillator-stopped mode first runs a start-up counter loaded from a configuration value, so the oscillator can settle. Every interrupt wake then holds the CPU for four more cycles with clocks running before it resumes. A reset event in any sleeping or waking state returns the block straight to normal running, with no hold, so the core restarts from its reset vector.

Top module: `slp_ctrl`

## Requirements
- R1: A `sleep_strobe` in the running state moves the block to sleep on the next clock edge only if `sleep_en` is 1 in the same cycle; with `sleep_en` at 0 the strobe leaves every output unchanged.
- R2: Mode encoding on `mode_sel` is 00 Idle, 01 ADC noise reduction, 10 Power-down, 11 Standby. While asleep, Idle gates only the CPU and flash clocks. ADC noise reduction also gates the I/O clock. Power-down and Standby gate all four domains.
- R3: `osc_stop` is 1 only while asleep in Power-down; Standby keeps the oscillator running.
- R4: Wake bits in `wake_req` are: bit0 other internal interrupt, bit1 edge-sensed external interrupt, bit2 ADC complete, bit3 EEPROM ready, bit4 serial start condition, bit5 level-sensed external interrupt, bit6 pin change. Idle accepts any bit. ADC noise reduction accepts bits 2 to 6. Power-down and Standby accept bits 4 to 6. Other bits leave the block asleep.
- R5: After an accepted wake, the block holds the CPU (`cpu_hold` = 1) for exactly 4 cycles with all clock enables at 1 and `osc_stop` at 0, then returns to running.
- R6: A wake from Power-down with a nonzero `startup_cfg` first spends exactly `startup_cfg` cycles in start-up, with all four clock domains gated, `osc_stop` at 0 and `cpu_hold` at 1, before the 4-cycle hold. With `startup_cfg` at 0 the start-up phase is skipped.
- R7: A wake from Standby, Idle or ADC noise reduction skips the start-up phase whatever `startup_cfg` holds.
- R8: `adc_start` is a single-cycle pulse that rises together with the entry into sleep, only if `adc_enabled` is 1 and the mode is Idle or ADC noise reduction.
- R9: Any bit of `rst_evt` (external, watchdog, brown-out) while asleep, in start-up or in hold returns the block to running on the next edge, with no hold cycles.
- R10: In the running state, including after reset, all clock enables are 1 and `cpu_hold` and `osc_stop` are 0; `wake_req` has no effect there.
- R11: The mode is captured when sleep is entered; a change of `mode_sel` while asleep does not change the gating or the accepted wake sources.
- R12: A `sleep_strobe` while the block is in start-up or hold is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_en | input | 1 | Sleep-enable control bit |
| mode_sel | input | 2 | Requested low-power mode |
| sleep_strobe | input | 1 | One-cycle sleep-instruction strobe |
| adc_enabled | input | 1 | ADC is enabled (allows the automatic conversion start) |
| wake_req | input | 7 | Enabled, pending wake sources by type |
| rst_evt | input | 3 | Reset events: external, watchdog, brown-out |
| startup_cfg | input | CNT_W | Oscillator start-up length in cycles |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| osc_stop | output | 1 | Oscillator stop request |
| adc_start | output | 1 | Automatic conversion start pulse |
| cpu_hold | output | 1 | CPU held (asleep, starting up or in wake hold) |

## Verification
The assertions watch on every cycle the properties that hold at single transitions. A strobe with sleep disabled never leaves the running state. A reset event always lands in running with the CPU released. The oscillator is never stopped while any clock runs, and the ADC pulse is isolated and only appears on sleep entry. The captured mode holds still while asleep, and the counter is never empty in a counting state. The length of the start-up and hold phases, the per-mode wake masks, and the per-mode gating can only be shown by the bench's scenarios. These scenarios count held cycles and compare them against an independent model over random and directed modes, wake vectors and start-up lengths.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_ADCNR = 2'b01,
    MODE_PDOWN = 2'b10,
    MODE_STBY  = 2'b11
  } slp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN     = 2'b00,
    ST_SLEEP   = 2'b01,
    ST_STARTUP = 2'b10,
    ST_HOLD    = 2'b11
  } slp_state_e;

  localparam int WAKE_W  = 7;
  localparam int RSTEV_W = 3;

  // wake vector bit positions
  localparam int WK_INT_OTHER = 0;
  localparam int WK_EXT_EDGE  = 1;
  localparam int WK_ADC_DONE  = 2;
  localparam int WK_EE_READY  = 3;
  localparam int WK_SER_START = 4;
  localparam int WK_EXT_LEVEL = 5;
  localparam int WK_PIN_CHG   = 6;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic osc_stop;
  } slp_gate_t;

  // which wake sources a given mode listens to
  function automatic logic [WAKE_W-1:0] wake_mask(input slp_mode_e m);
    logic [WAKE_W-1:0] msk;
    msk = '0;
    msk[WK_SER_START] = 1'b1;
    msk[WK_EXT_LEVEL] = 1'b1;
    msk[WK_PIN_CHG]   = 1'b1;
    if (m == MODE_IDLE || m == MODE_ADCNR) begin
      msk[WK_ADC_DONE] = 1'b1;
      msk[WK_EE_READY] = 1'b1;
    end
    if (m == MODE_IDLE) begin
      msk[WK_INT_OTHER] = 1'b1;
      msk[WK_EXT_EDGE]  = 1'b1;
    end
    return msk;
  endfunction

endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
  import slp_pkg::*;
(
  input  slp_mode_e         mode,
  input  logic [WAKE_W-1:0] wake_req,
  output logic              wake_hit,
  output logic              need_startup
);
  logic [WAKE_W-1:0] allowed;

  always_comb begin
    allowed      = wake_req & wake_mask(mode);
    wake_hit     = |allowed;
    need_startup = (mode == MODE_PDOWN);
  end
endmodule

// File: rtl/slp_gate_map.sv
module slp_gate_map
  import slp_pkg::*;
(
  input  slp_state_e state,
  input  slp_mode_e  mode,
  output slp_gate_t  gate
);
  always_comb begin
    gate = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, osc_stop: 1'b0};
    unique case (state)
      ST_SLEEP: begin
        gate.cpu   = 1'b0;
        gate.flash = 1'b0;
        unique case (mode)
          MODE_IDLE:  ;
          MODE_ADCNR: gate.io = 1'b0;
          MODE_PDOWN: begin
            gate.io       = 1'b0;
            gate.adc      = 1'b0;
            gate.osc_stop = 1'b1;
          end
          MODE_STBY: begin
            gate.io  = 1'b0;
            gate.adc = 1'b0;
          end
          default: ;
        endcase
      end
      ST_STARTUP: begin
        // oscillator restarting, nothing clocked yet
        gate.cpu   = 1'b0;
        gate.flash = 1'b0;
        gate.io    = 1'b0;
        gate.adc   = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/slp_delay_cnt.sv
module slp_delay_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             count_en,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = load | (count_en & (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  // a counting phase never sits on an empty counter
  assert_cnt_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> (cnt_q != '0));
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HOLD_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_en,
  input  logic [1:0]         mode_sel,
  input  logic               sleep_strobe,
  input  logic               adc_enabled,
  input  logic [6:0]         wake_req,
  input  logic [2:0]         rst_evt,
  input  logic [CNT_W-1:0]   startup_cfg,
  output logic               cpu_clk_en,
  output logic               flash_clk_en,
  output logic               io_clk_en,
  output logic               adc_clk_en,
  output logic               osc_stop,
  output logic               adc_start,
  output logic               cpu_hold
);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC);

  logic       rst_sync_n;
  slp_state_e state_q, state_d;
  slp_mode_e  mode_q, mode_d;
  logic       mode_ce;
  logic       adc_start_q, adc_start_d;
  logic       wake_hit, need_startup;
  logic       cnt_load, cnt_last, cnt_en;
  logic [CNT_W-1:0] cnt_val;
  slp_gate_t  gate;
  logic       enter_ok;

  slp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  slp_wake_filter u_wake (
    .mode         (mode_q),
    .wake_req     (wake_req),
    .wake_hit     (wake_hit),
    .need_startup (need_startup)
  );

  assign cnt_en = (state_q == ST_STARTUP) || (state_q == ST_HOLD);

  slp_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .count_en (cnt_en),
    .last     (cnt_last)
  );

  slp_gate_map u_gate (
    .state (state_q),
    .mode  (mode_q),
    .gate  (gate)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    mode_d      = mode_q;
    mode_ce     = 1'b0;
    adc_start_d = 1'b0;
    cnt_load    = 1'b0;
    cnt_val     = HOLD_LOAD;
    enter_ok    = sleep_strobe && sleep_en;
    if (|rst_evt) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (enter_ok) begin
            state_d     = ST_SLEEP;
            mode_d      = slp_mode_e'(mode_sel);
            mode_ce     = 1'b1;
            adc_start_d = adc_enabled &&
                          (mode_sel == MODE_IDLE || mode_sel == MODE_ADCNR);
          end
        end
        ST_SLEEP: begin
          if (wake_hit) begin
            cnt_load = 1'b1;
            if (need_startup && (startup_cfg != '0)) begin
              state_d = ST_STARTUP;
              cnt_val = startup_cfg;
            end else begin
              state_d = ST_HOLD;
            end
          end
        end
        ST_STARTUP: begin
          if (cnt_last) begin
            state_d  = ST_HOLD;
            cnt_load = 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_last) state_d = ST_RUN;
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q     <= ST_RUN;
      adc_start_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      adc_start_q <= adc_start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mode_q <= MODE_IDLE;
    else if (mode_ce) mode_q <= mode_d;
  end

  assign cpu_clk_en   = gate.cpu;
  assign flash_clk_en = gate.flash;
  assign io_clk_en    = gate.io;
  assign adc_clk_en   = gate.adc;
  assign osc_stop     = gate.osc_stop;
  assign adc_start    = adc_start_q;
  assign cpu_hold     = (state_q != ST_RUN);

  // strobe with sleep disabled keeps running
  assert_no_entry_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_RUN && sleep_strobe && !sleep_en) |=> (state_q == ST_RUN));

  // a stopped oscillator implies every domain is gated
  assert_osc_gated_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    osc_stop |-> (!cpu_clk_en && !flash_clk_en && !io_clk_en && !adc_clk_en));

  // start-up: oscillator on, CPU still off
  assert_startup_gate_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_STARTUP) |-> (!osc_stop && !cpu_clk_en && cpu_hold));

  // conversion pulse is isolated and only accompanies sleep
  assert_adc_pulse_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adc_start |-> (cpu_hold && !cpu_clk_en) ##1 !adc_start);

  // reset event always lands in running
  assert_rst_evt_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|rst_evt) |=> (!cpu_hold && cpu_clk_en && !osc_stop));

  // captured mode stays fixed while asleep
  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_SLEEP && state_d == ST_SLEEP) |=> $stable(mode_q));
endmodule

// File: tb/slp_ctrl_tb.sv
`timescale 1ns/1ps
module slp_ctrl_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, sleep_en, sleep_strobe, adc_enabled;
  logic [1:0]       mode_sel;
  logic [6:0]       wake_req;
  logic [2:0]       rst_evt;
  logic [CNT_W-1:0] startup_cfg;
  logic cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, osc_stop, adc_start, cpu_hold;

  slp_ctrl #(.CNT_W(CNT_W), .HOLD_CYC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .mode_sel(mode_sel),
    .sleep_strobe(sleep_strobe), .adc_enabled(adc_enabled), .wake_req(wake_req),
    .rst_evt(rst_evt), .startup_cfg(startup_cfg), .cpu_clk_en(cpu_clk_en),
    .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en), .adc_clk_en(adc_clk_en),
    .osc_stop(osc_stop), .adc_start(adc_start), .cpu_hold(cpu_hold)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  localparam logic [4:0] GATE_RUN = 5'b11110;

  function automatic logic [4:0] gates();
    return {cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, osc_stop};
  endfunction

  // {cpu, flash, io, adc, osc_stop} while asleep
  function automatic logic [4:0] exp_sleep_gate(input logic [1:0] m);
    case (m)
      2'b00:   return 5'b00110;
      2'b01:   return 5'b00010;
      2'b10:   return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic bit exp_wake(input logic [1:0] m, input logic [6:0] w);
    logic [6:0] msk;
    case (m)
      2'b00:   msk = 7'h7F;
      2'b01:   msk = 7'h7C;
      default: msk = 7'h70;
    endcase
    return |(w & msk);
  endfunction

  function automatic int exp_held(input logic [1:0] m, input int cfg);
    return (m == 2'b10 && cfg > 0) ? cfg + 4 : 4;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_hold(input int exp, input string req);
    int c = 0;
    while (cpu_hold && c < 100000) begin
      c++;
      @(negedge clk);
    end
    check(c == exp, req, "held cycles", c, exp);
    check(gates() == GATE_RUN, "R10", "gates after wake", gates(), GATE_RUN);
  endtask

  // full sleep/wake scenario; returns at a negedge in the running state
  task automatic scenario(input logic [1:0] m, input bit en, input bit ae,
                          input logic [6:0] w, input int cfg, input bit strobe_in_hold);
    @(negedge clk);
    mode_sel = m; sleep_en = en; adc_enabled = ae;
    startup_cfg = CNT_W'(cfg); sleep_strobe = 1'b1;
    @(negedge clk);
    sleep_strobe = 1'b0;
    if (!en) begin
      check(!cpu_hold, "R1", "hold after disabled strobe", cpu_hold, 0);
      check(gates() == GATE_RUN, "R1", "gates after disabled strobe", gates(), GATE_RUN);
      check(!adc_start, "R8", "adc pulse on no entry", adc_start, 0);
      return;
    end
    check(cpu_hold, "R1", "asleep after strobe", cpu_hold, 1);
    check(gates() == exp_sleep_gate(m), (m == 2'b10) ? "R3" : "R2", "sleep gating",
          gates(), exp_sleep_gate(m));
    check(adc_start == (ae && m[1] == 1'b0), "R8", "adc pulse on entry",
          adc_start, int'(ae && m[1] == 1'b0));
    mode_sel = ~m;              // R11: must be ignored while asleep
    wake_req = w;
    @(negedge clk);
    check(!adc_start, "R8", "adc pulse width", adc_start, 0);
    if (!exp_wake(m, w)) begin
      check(cpu_hold, "R4", "masked wake ignored", cpu_hold, 1);
      check(gates() == exp_sleep_gate(m), "R11", "gating after mode change",
            gates(), exp_sleep_gate(m));
      wake_req = 7'h40;
      @(negedge clk);
    end
    wake_req = '0;
    check(cpu_hold, "R4", "hold on wake", cpu_hold, 1);
    if (m == 2'b10 && cfg > 0)
      check(gates() == 5'b00000, "R6", "start-up gating", gates(), 0);
    else
      check(gates() == GATE_RUN, "R5", "hold gating", gates(), GATE_RUN);
    if (strobe_in_hold) begin
      sleep_en = 1'b1; sleep_strobe = 1'b1;
      @(negedge clk);
      sleep_strobe = 1'b0;
      count_hold(exp_held(m, cfg) - 1, "R12");
    end else begin
      count_hold(exp_held(m, cfg), (m == 2'b10) ? "R6" : (m == 2'b11 ? "R7" : "R5"));
    end
  endtask

  task automatic reset_event_case(input logic [1:0] m, input int cfg, input int delay,
                                  input logic [2:0] ev);
    @(negedge clk);
    mode_sel = m; sleep_en = 1'b1; startup_cfg = CNT_W'(cfg); sleep_strobe = 1'b1;
    @(negedge clk);
    sleep_strobe = 1'b0;
    if (delay > 0) begin
      wake_req = 7'h20;
      @(negedge clk);
      wake_req = '0;
      for (int i = 1; i < delay; i++) @(negedge clk);
    end
    rst_evt = ev;
    @(negedge clk);
    rst_evt = '0;
    check(!cpu_hold, "R9", "running after reset event", cpu_hold, 0);
    check(gates() == GATE_RUN, "R9", "gates after reset event", gates(), GATE_RUN);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1A2B3C4D);
    rst_n = 1'b0; sleep_en = 1'b0; sleep_strobe = 1'b0; adc_enabled = 1'b0;
    mode_sel = '0; wake_req = '0; rst_evt = '0; startup_cfg = '0;
    repeat (3) @(negedge clk);
    check(gates() == GATE_RUN && !cpu_hold && !adc_start, "R10", "reset state",
          gates(), GATE_RUN);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: wake requests in running state do nothing
    wake_req = 7'h7F;
    repeat (3) @(negedge clk);
    wake_req = '0;
    check(!cpu_hold && gates() == GATE_RUN, "R10", "wake in run ignored", cpu_hold, 0);

    // directed cases
    scenario(2'b00, 1'b0, 1'b1, 7'h01, 0, 1'b0);   // R1 disabled
    scenario(2'b00, 1'b1, 1'b1, 7'h02, 5, 1'b0);   // Idle edge wake
    scenario(2'b01, 1'b1, 1'b1, 7'h03, 5, 1'b0);   // R4 ANR ignores bits 0,1
    scenario(2'b10, 1'b1, 1'b1, 7'h0E, 9, 1'b0);   // R4/R6 PD ignores edge
    scenario(2'b10, 1'b1, 1'b0, 7'h10, 0, 1'b0);   // R6 zero start-up
    scenario(2'b11, 1'b1, 1'b1, 7'h20, 30, 1'b0);  // R7 standby no start-up
    scenario(2'b00, 1'b1, 1'b0, 7'h40, 0, 1'b1);   // R12 strobe during hold
    scenario(2'b10, 1'b1, 1'b0, 7'h40, 3, 1'b1);   // R12 strobe during start-up

    reset_event_case(2'b11, 0, 0, 3'b001);         // R9 from sleep
    reset_event_case(2'b10, 12, 3, 3'b010);        // R9 from start-up
    reset_event_case(2'b01, 0, 2, 3'b100);         // R9 from hold

    // constrained random
    for (int k = 0; k < 80; k++) begin
      logic [1:0] m;
      logic [6:0] w;
      int cfg;
      bit en, ae;
      m   = 2'($urandom_range(0, 3));
      en  = ($urandom_range(0, 5) != 0);
      ae  = 1'($urandom_range(0, 1));
      w   = ($urandom_range(0, 1) == 1) ? 7'(1 << $urandom_range(0, 6))
                                          : 7'($urandom_range(0, 127));
      cfg = $urandom_range(0, 40);
      scenario(m, en, ae, w, cfg, 1'b0);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule